// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Port

This block gives a processor a full-duplex asynchronous serial line through four byte-wide registers. It is reached with a chip enable, one register-select line, read and write strobes, an 8-bit input bus and an 8-bit output bus with an output-enable. A write to the transmit slot parks a byte in a holding register. The transmitter then moves it into its own shift register and sends it as a start bit, 5 to 8 data bits (least significant first), an optional parity bit and one or two stop bits. The receiver oversamples the line at 16 ticks per bit. It confirms a start bit at its middle, samples every later bit at its centre, and copies the finished byte into the receive register together with ready and error flags.

The control register selects the character format and the bit rate. One bit time is 16 × (rate + 1) × `BASE_DIV` clock cycles, so software picks one of eight speeds without stopping the clock. The transmitter has states TX_IDLE, TX_START, TX_DATA, TX_PARITY and TX_STOP:
- TX_IDLE goes to TX_START when the holding register is full, and loads the byte at that moment.
- TX_START goes to TX_DATA after 16 ticks.
- TX_DATA goes to TX_PARITY, or to TX_STOP when parity is off, once the last data bit ends.
- TX_PARITY goes to TX_STOP.
- TX_STOP goes back to TX_IDLE after one or two stop bits.

The receiver has states RX_IDLE, RX_START, RX_DATA, RX_PARITY and RX_STOP:
- RX_IDLE goes to RX_START on a low sample.
- RX_START goes to RX_DATA if the line is still low at mid-bit, and back to RX_IDLE otherwise.
- RX_DATA goes to RX_PARITY or RX_STOP after the last data centre.
- RX_PARITY goes to RX_STOP.
- RX_STOP goes to RX_IDLE at the stop-bit centre, where the byte and its flags are delivered.

Top module: `serial_port_core`

## Requirements
- R1: After reset the serial output is 1, the output-enable is 0, and a status read returns 0x01.
- R2: While chip enable is 0, the output-enable is 0, the output bus is 0x00, and writes change nothing. An access with both strobes high acts only as a read. With chip enable high, select 0 with write loads the transmit slot, select 1 with write loads control, select 0 with read returns received data, and select 1 with read returns status.
- R3: The serial output stays at 1 whenever no character is in progress.
- R4: A character starts with one 0 bit, followed at once by the data bits least significant first. The count is 5 + control[1:0]. Every bit lasts 16 × (control[7:5] + 1) × BASE_DIV clocks.
- R5: With control[3] = 1 a parity bit follows the data bits. Its value is the XOR of the data bits, inverted when control[4] = 1 (odd parity).
- R6: Control[2] = 0 gives one stop bit of 1 and control[2] = 1 gives two. A queued next character starts right after the last stop bit.
- R7: Status[0] (holding empty) drops to 0 on a transmit write and returns to 1 once the byte has moved to the shift register, so a second byte can be queued during a frame.
- R8: A low pulse shorter than half a bit is ignored. A valid character lands right-aligned in the receive register and sets status[1]. Reading the receive register clears status[1].
- R9: A parity mismatch on a received character sets status[2].
- R10: A first stop bit sampled as 0 sets status[3].
- R11: A character completing while status[1] is still set sets status[4], and the new byte replaces the old one.
- R12: A status read clears status[4:2]. An error arriving in the same cycle as the read is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip enable |
| rsel | input | 1 | Register select |
| rd | input | 1 | Read strobe, one access per cycle high |
| wr | input | 1 | Write strobe, one access per cycle high |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, 0x00 when not driven |
| dout_oe | output | 1 | Read data valid / bus drive enable |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |

## Verification
The bench attacks the format corners and mixes them with random ones:
- **Character length.** Lengths of 5 and 8 bits are covered. A wrong length count shifts the parity and stop bits into the wrong slots.
- **Parity sense.** Both even and odd parity are used. A flipped parity sense shows up as a wrong parity bit or a false parity error.
- **Stop-bit count.** The gap to a queued second character is measured. A transmitter that ignores the stop-count bit starts the next frame a bit early or late.
- **Receive faults.** Directed cases drive a runt start pulse, a bad parity bit, a zero stop bit and two unread characters in a row. These catch a receiver that starts on glitches, loses or keeps error flags wrongly, or fails to flag and replace on overrun.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int OVS = 16;

    typedef struct packed {
        logic [2:0] rate;
        logic       par_odd;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len;
    } ctrl_t;

    typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PARITY, TX_STOP} tx_state_e;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PARITY, RX_STOP} rx_state_e;

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction
endpackage

// File: rtl/sp_baud_tick.sv
module sp_baud_tick #(
    parameter int BASE_DIV = 1,
    parameter int RATE_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_DIV = (2 ** RATE_W) * BASE_DIV;
    localparam int CNT_W   = $clog2(MAX_DIV + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'((int'(rate) + 1) * BASE_DIV - 1);
    assign tick  = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_two_stop,
    input  logic       hold_full,
    input  logic [7:0] hold_data,
    output logic       take,
    output logic       idle,
    output logic       txd
);
    tx_state_e  state, nstate;
    logic [3:0] ph;
    logic [2:0] idx;
    logic [2:0] nbits_m1;
    logic [7:0] shreg;
    logic       par_bit, par_en_q, two_stop_q;
    logic       bit_end;

    assign bit_end = tick && (ph == 4'(OVS - 1));
    assign take    = (state == TX_IDLE) && hold_full;
    assign idle    = (state == TX_IDLE);

    always_comb begin
        nstate = state;
        unique case (state)
            TX_IDLE:   if (hold_full) nstate = TX_START;
            TX_START:  if (bit_end) nstate = TX_DATA;
            TX_DATA:   if (bit_end && idx == nbits_m1) nstate = par_en_q ? TX_PARITY : TX_STOP;
            TX_PARITY: if (bit_end) nstate = TX_STOP;
            TX_STOP:   if (bit_end && (!two_stop_q || idx == 3'd1)) nstate = TX_IDLE;
            default:   nstate = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            ph         <= '0;
            idx        <= '0;
            nbits_m1   <= 3'd7;
            shreg      <= '0;
            par_bit    <= 1'b0;
            par_en_q   <= 1'b0;
            two_stop_q <= 1'b0;
        end else begin
            state <= nstate;
            if (take) begin
                shreg      <= hold_data;
                nbits_m1   <= 3'd4 + {1'b0, cfg_len};
                par_bit    <= (^(hold_data & len_mask(cfg_len))) ^ cfg_par_odd;
                par_en_q   <= cfg_par_en;
                two_stop_q <= cfg_two_stop;
                ph         <= '0;
                idx        <= '0;
            end else if (tick) begin
                ph <= ph + 1'b1;
                if (bit_end) begin
                    if (state == TX_DATA) begin
                        shreg <= shreg >> 1;
                        idx   <= (idx == nbits_m1) ? 3'd0 : idx + 1'b1;
                    end else if (state == TX_STOP) begin
                        idx <= idx + 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_IDLE:   txd = 1'b1;
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg[0];
            TX_PARITY: txd = par_bit;
            TX_STOP:   txd = 1'b1;
            default:   txd = 1'b1;
        endcase
    end
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data,
    output logic       perr,
    output logic       ferr
);
    logic line;

    generate
        if (SYNC_STAGES < 2) begin : g_sync1
            logic s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= 1'b1;
                else        s_q <= rxd;
            end
            assign line = s_q;
        end else begin : g_syncn
            logic [SYNC_STAGES-1:0] s_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) s_q <= '1;
                else        s_q <= {s_q[SYNC_STAGES-2:0], rxd};
            end
            assign line = s_q[SYNC_STAGES-1];
        end
    endgenerate

    rx_state_e  state, nstate;
    logic [3:0] ph;
    logic [2:0] idx, nbits_m1;
    logic [7:0] shreg, aligned;
    logic       pbit, par_en_q, par_odd_q;
    logic       mid;

    assign mid     = tick && (ph == 4'(OVS - 1));
    assign aligned = shreg >> (3'd7 - nbits_m1);

    always_comb begin
        nstate = state;
        unique case (state)
            RX_IDLE:   if (tick && !line) nstate = RX_START;
            RX_START:  if (tick && ph == 4'(OVS / 2 - 1)) nstate = line ? RX_IDLE : RX_DATA;
            RX_DATA:   if (mid && idx == nbits_m1) nstate = par_en_q ? RX_PARITY : RX_STOP;
            RX_PARITY: if (mid) nstate = RX_STOP;
            RX_STOP:   if (mid) nstate = RX_IDLE;
            default:   nstate = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            ph        <= '0;
            idx       <= '0;
            nbits_m1  <= 3'd7;
            shreg     <= '0;
            pbit      <= 1'b0;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
        end else begin
            state <= nstate;
            if (tick) begin
                if (state == RX_IDLE) begin
                    ph        <= '0;
                    idx       <= '0;
                    nbits_m1  <= 3'd4 + {1'b0, cfg_len};
                    par_en_q  <= cfg_par_en;
                    par_odd_q <= cfg_par_odd;
                end else if (state == RX_START && ph == 4'(OVS / 2 - 1)) begin
                    ph <= '0;
                end else begin
                    ph <= ph + 1'b1;
                end
                if (mid && state == RX_DATA) begin
                    shreg <= {line, shreg[7:1]};
                    idx   <= idx + 1'b1;
                end
                if (mid && state == RX_PARITY) pbit <= line;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if (mid && state == RX_STOP) begin
                done <= 1'b1;
                data <= aligned;
                perr <= par_en_q && ((^aligned) ^ pbit ^ par_odd_q);
                ferr <= !line;
            end
        end
    end
endmodule

// File: rtl/serial_port_core.sv
module serial_port_core
    import sp_pkg::*;
#(
    parameter int BASE_DIV    = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs,
    input  logic       rsel,
    input  logic       rd,
    input  logic       wr,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       dout_oe,
    output logic       txd,
    input  logic       rxd
);
    ctrl_t      ctrl_q;
    logic [7:0] hold_q, rx_q, status;
    logic       hold_full, rx_ready, perr_q, ferr_q, ovr_q;
    logic       tick, tx_take, tx_idle;
    logic       rx_done, rx_perr, rx_ferr;
    logic [7:0] rx_data;
    logic       acc_tx_wr, acc_ctl_wr, acc_rx_rd, acc_st_rd;

    assign acc_tx_wr  = cs && wr && !rd && !rsel;
    assign acc_ctl_wr = cs && wr && !rd && rsel;
    assign acc_rx_rd  = cs && rd && !rsel;
    assign acc_st_rd  = cs && rd && rsel;

    assign status  = {3'b000, ovr_q, ferr_q, perr_q, rx_ready, !hold_full};
    assign dout_oe = cs && rd;
    assign dout    = acc_rx_rd ? rx_q : (acc_st_rd ? status : 8'h00);

    sp_baud_tick #(.BASE_DIV(BASE_DIV), .RATE_W(3)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .rate (ctrl_q.rate),
        .tick (tick)
    );

    sp_tx u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cfg_len     (ctrl_q.len),
        .cfg_par_en  (ctrl_q.par_en),
        .cfg_par_odd (ctrl_q.par_odd),
        .cfg_two_stop(ctrl_q.two_stop),
        .hold_full   (hold_full),
        .hold_data   (hold_q),
        .take        (tx_take),
        .idle        (tx_idle),
        .txd         (txd)
    );

    sp_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cfg_len    (ctrl_q.len),
        .cfg_par_en (ctrl_q.par_en),
        .cfg_par_odd(ctrl_q.par_odd),
        .rxd        (rxd),
        .done       (rx_done),
        .data       (rx_data),
        .perr       (rx_perr),
        .ferr       (rx_ferr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= ctrl_t'(8'h03);
            hold_q    <= '0;
            hold_full <= 1'b0;
            rx_q      <= '0;
            rx_ready  <= 1'b0;
            perr_q    <= 1'b0;
            ferr_q    <= 1'b0;
            ovr_q     <= 1'b0;
        end else begin
            if (acc_ctl_wr) ctrl_q <= ctrl_t'(din);
            if (acc_tx_wr) begin
                hold_q    <= din;
                hold_full <= 1'b1;
            end else if (tx_take) begin
                hold_full <= 1'b0;
            end
            if (acc_rx_rd) rx_ready <= 1'b0;
            if (acc_st_rd) begin
                perr_q <= 1'b0;
                ferr_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
            if (rx_done) begin
                rx_q     <= rx_data;
                rx_ready <= 1'b1;
                if (rx_perr) perr_q <= 1'b1;
                if (rx_ferr) ferr_q <= 1'b1;
                if (rx_ready && !acc_rx_rd) ovr_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sp_checker.sv
module sp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs,
    input logic       rsel,
    input logic       rd,
    input logic       wr,
    input logic [7:0] dout,
    input logic       dout_oe,
    input logic       txd,
    input logic       tx_take,
    input logic       tx_idle,
    input logic       hold_full,
    input logic       rx_done,
    input logic       rx_ready,
    input logic       perr_q,
    input logic       ferr_q,
    input logic       ovr_q
);
    p_bus_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && rd) |-> (!dout_oe && dout == 8'h00));

    p_line_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_idle |-> txd);

    p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !txd);

    p_hold_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && wr && !rd && !rsel) |=> hold_full);

    p_ready_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && !rsel && !rx_done) |=> !rx_ready);

    p_overrun_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rx_ready && !(cs && rd && !rsel)) |=> ovr_q);

    p_err_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && rsel && !rx_done) |=> (!perr_q && !ferr_q && !ovr_q));
endmodule

bind serial_port_core sp_checker u_sp_checker (.*);

// File: tb/serial_port_core_tb_top.sv
`timescale 1ns/1ps
module serial_port_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rsel = 1'b0, rd = 1'b0, wr = 1'b0, rxd = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe, txd;
    int         n_chk = 0, n_fail = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;

    serial_port_core dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rsel(rsel), .rd(rd), .wr(wr),
        .din(din), .dout(dout), .dout_oe(dout_oe), .txd(txd), .rxd(rxd)
    );

    function automatic int bitp(input logic [7:0] c);
        return 16 * (int'(c[7:5]) + 1);
    endfunction
    function automatic int nbits(input logic [7:0] c);
        return 5 + int'(c[1:0]);
    endfunction
    function automatic logic [7:0] dmask(input logic [7:0] c);
        return 8'hFF >> (3 - int'(c[1:0]));
    endfunction
    function automatic logic parity_of(input logic [7:0] c, input logic [7:0] d);
        return (^(d & dmask(c))) ^ c[4];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic s, input logic [7:0] v);
        @(negedge clk); cs = 1; wr = 1; rsel = s; din = v;
        @(negedge clk); cs = 0; wr = 0;
    endtask

    task automatic bus_read(input logic s, output logic [7:0] v);
        @(negedge clk); cs = 1; rd = 1; rsel = s;
        #1 v = dout;
        @(negedge clk); cs = 0; rd = 0;
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Decode one frame on txd; optionally measure the gap to the next start.
    task automatic tx_monitor(input logic [7:0] c, input logic [7:0] d, input bit gap);
        int p = bitp(c);
        int t = 0;
        while (txd !== 1'b0 && t < 40 * p) begin @(negedge clk); t++; end
        check("R4 start edge seen", {31'b0, txd}, 32'd0);
        wait_clks(p / 2);
        check("R4 start bit", {31'b0, txd}, 32'd0);
        for (int i = 0; i < nbits(c); i++) begin
            wait_clks(p);
            check("R4 data bit", {31'b0, txd}, {31'b0, d[i]});
        end
        if (c[3]) begin
            wait_clks(p);
            check("R5 parity bit", {31'b0, txd}, {31'b0, parity_of(c, d)});
        end
        for (int s = 0; s < (c[2] ? 2 : 1); s++) begin
            wait_clks(p);
            check("R6 stop bit", {31'b0, txd}, 32'd1);
        end
        if (gap) begin
            t = 0;
            while (txd !== 1'b0 && t < 4 * p) begin @(negedge clk); t++; end
            check("R6 gap to next frame",
                  {31'b0, (t >= p / 2 - int'(c[7:5]) - 4) && (t <= p / 2 + int'(c[7:5]) + 4)}, 32'd1);
        end
    endtask

    task automatic rx_drive(input logic [7:0] c, input logic [7:0] d, input bit bad_par, input bit bad_stop);
        int p = bitp(c);
        rxd = 0; wait_clks(p);
        for (int i = 0; i < nbits(c); i++) begin rxd = d[i]; wait_clks(p); end
        if (c[3]) begin rxd = parity_of(c, d) ^ bad_par; wait_clks(p); end
        if (bad_stop) begin
            rxd = 0; wait_clks(p / 2 + 2 * (int'(c[7:5]) + 1) + 4);
            rxd = 1; wait_clks(p);
        end else begin
            rxd = 1; wait_clks(p);
        end
        wait_clks(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, c, a, b;
        int unsigned seed_init;
        int t;
        seed_init = $urandom(32'd20240611);
        wait_clks(3);
        rst_n = 1;
        wait_clks(2);

        // R1 reset state
        check("R1 txd after reset", {31'b0, txd}, 32'd1);
        check("R1 oe after reset", {31'b0, dout_oe}, 32'd0);
        bus_read(1'b1, v);
        check("R1 status after reset", {24'b0, v}, 32'h01);

        // R2 deselected and dual-strobe accesses
        @(negedge clk); cs = 0; rd = 1; wr = 1; rsel = 0; din = 8'h55;
        #1 check("R2 oe with cs low", {31'b0, dout_oe}, 32'd0);
        check("R2 dout with cs low", {24'b0, dout}, 32'h00);
        @(negedge clk); rd = 0; wr = 0;
        @(negedge clk); cs = 1; rd = 1; wr = 1; rsel = 0; din = 8'hA5;
        @(negedge clk); cs = 0; rd = 0; wr = 0;
        t = 0;
        for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1'b1) t++; end
        check("R2 R3 no frame from ignored writes", t, 32'd0);
        bus_read(1'b1, v);
        check("R2 status unchanged", {24'b0, v}, 32'h01);

        // Directed corners: 5-bit odd parity two stops, 8-bit even one stop.
        for (int k = 0; k < 14; k++) begin
            if (k == 0)      c = 8'b000_1_1_1_00;
            else if (k == 1) c = 8'b001_0_1_0_11;
            else begin
                c = 8'($urandom);
                c[7:5] = 3'($urandom_range(0, 1));
            end
            a = 8'($urandom); b = 8'($urandom);
            bus_write(1'b1, c);
            bus_write(1'b0, a);
            t = 0;
            do begin bus_read(1'b1, v); t++; end while (!v[0] && t < 50);
            check("R7 holding empty after take", {31'b0, v[0]}, 32'd1);
            bus_write(1'b0, b);
            bus_read(1'b1, v);
            check("R7 holding full after write", {31'b0, v[0]}, 32'd0);
            tx_monitor(c, a, 1'b1);
            tx_monitor(c, b, 1'b0);
            wait_clks(bitp(c));
            check("R3 idle line after frame", {31'b0, txd}, 32'd1);

            // receive the same format
            rx_drive(c, a, 1'b0, 1'b0);
            bus_read(1'b1, v);
            check("R8 status after good frame", {24'b0, v}, 32'h03);
            bus_read(1'b0, v);
            check("R8 received byte", {24'b0, v}, {24'b0, a & dmask(c)});
            bus_read(1'b1, v);
            check("R8 ready cleared by read", {24'b0, v}, 32'h01);
        end

        // R8 runt start pulse
        bus_write(1'b1, 8'h03);
        @(negedge clk); rxd = 0; wait_clks(3); rxd = 1;
        wait_clks(64);
        bus_read(1'b1, v);
        check("R8 runt pulse ignored", {24'b0, v}, 32'h01);

        // R9 parity error, then R12 clear
        c = 8'b000_0_1_0_11;
        bus_write(1'b1, c);
        rx_drive(c, 8'h3C, 1'b1, 1'b0);
        bus_read(1'b0, v);
        check("R9 byte with parity error", {24'b0, v}, 32'h3C);
        bus_read(1'b1, v);
        check("R9 parity error flag", {24'b0, v}, 32'h05);
        bus_read(1'b1, v);
        check("R12 errors cleared by status read", {24'b0, v}, 32'h01);

        // R10 framing error
        c = 8'h03;
        bus_write(1'b1, c);
        rx_drive(c, 8'hC3, 1'b0, 1'b1);
        bus_read(1'b1, v);
        check("R10 framing error flag", {24'b0, v}, 32'h0B);
        bus_read(1'b1, v);
        check("R12 framing cleared", {24'b0, v}, 32'h03);
        bus_read(1'b0, v);

        // R11 overrun
        rx_drive(c, 8'h11, 1'b0, 1'b0);
        rx_drive(c, 8'h22, 1'b0, 1'b0);
        bus_read(1'b1, v);
        check("R11 overrun flag", {24'b0, v}, 32'h13);
        bus_read(1'b1, v);
        check("R12 overrun cleared, ready kept", {24'b0, v}, 32'h03);
        bus_read(1'b0, v);
        check("R11 newest byte kept", {24'b0, v}, 32'h22);
        bus_read(1'b1, v);
        check("R8 final status", {24'b0, v}, 32'h01);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule